// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line back into bytes. It runs on the system clock and takes a one-cycle sample enable that pulses at sixteen times the baud rate. While idle it only watches for the line to fall from its high rest level. After a fall it waits half a bit period to reach the middle of the start bit. It then samples every following bit once per sixteen enables, so each sample lands near the middle of its bit.

A frame lasts eleven bit periods: a low start bit, eight data bits sent least significant first, and two stop bits. A byte is kept only when both stop bits read high. Kept bytes go into a four-entry receive queue. The host sees the oldest byte at the output and removes it with a read strobe.

Three sticky status bits report lost data, a bad frame and a line break. Reading the status clears them. If the line has returned high by the middle of the start bit, the block treats the fall as noise and goes back to idle without reporting anything.

Top module: `os_serial_rx`

## Requirements
- R1: After reset `rd_valid_o` is 0 and `stat_o` is 3'b000; the serial input is treated as idle-high through a two-flop synchroniser.
- R2: A low pulse on `line_i` that has ended before the middle of the start bit (8 enables after the fall) produces no byte and no status bit. A line held high produces nothing.
- R3: A frame is a low start bit, then 8 data bits least significant first, then two stop bits, each bit lasting 16 enables. A frame whose stop bits are both high places its byte in the queue, and the byte appears on `rd_data_o` with `rd_valid_o` high.
- R4: The queue holds up to 4 bytes and delivers them in arrival order. `rd_data_o` shows the oldest byte. A one-cycle `rd_en_i` while `rd_valid_o` is high removes it. `rd_valid_o` falls only after a removal.
- R5: A valid byte that arrives while the queue is full and no removal occurs in that cycle is discarded, the queue contents are unchanged, and `stat_o[0]` (overrun) is set.
- R6: If either stop bit is sampled low and the frame is not a break, the byte is discarded and `stat_o[1]` (framing) is set. This includes the case where only the second stop bit is low.
- R7: A frame whose start, data and stop samples are all low is a break. It sets `stat_o[2]` only, leaves `stat_o[1]` clear and stores no byte.
- R8: Status bits stay set until a one-cycle `stat_rd_i` clears all of them. An event in the same cycle as the clear leaves its own bit set.
- R9: A valid byte that completes in the same cycle as a removal from a full queue is stored, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample enable, one cycle wide, at 16x baud |
| line_i | input | 1 | Asynchronous serial input, high when idle |
| rd_en_i | input | 1 | Remove the oldest byte from the queue |
| rd_data_o | output | 8 | Oldest byte in the queue |
| rd_valid_o | output | 1 | Queue holds at least one byte |
| stat_rd_i | input | 1 | Status read strobe; clears the status bits |
| stat_o | output | 3 | Sticky status: bit0 overrun, bit1 framing, bit2 break |

## Verification
Two pairs of events can land in the same clock cycle: a status clear with a new framing event, and a host removal from a full queue with the arrival of a new byte. The bench first measures, at the ports, the cycle in which the end of a frame becomes visible, and it always starts frames at the same phase of the sample enable. It then repeats the frame with the clear strobe or the read strobe placed exactly on that cycle. It judges the result by the status bits that survive and by draining the queue to confirm that the new byte was kept behind the three older ones.

// File: rtl/os_rx_pkg.sv
package os_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned STOP_N = 2;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned STAT_OVR = 0;
  localparam int unsigned STAT_FRM = 1;
  localparam int unsigned STAT_BRK = 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef logic [DATA_W-1:0] rx_byte_t;
  typedef logic [STOP_N-1:0] rx_stops_t;

  // every stop sample must be high for a frame to be accepted
  function automatic logic stops_good(rx_stops_t s);
    return &s;
  endfunction

  // break: data and stop samples all low (start already known low)
  function automatic logic frame_is_break(rx_byte_t d, rx_stops_t s);
    return (d == '0) && (s == '0);
  endfunction
endpackage

// File: rtl/os_rx_sync.sv
module os_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[g] <= 1'b1;
      end else if (g == 0) begin
        chain_q[g] <= d_i;
      end else begin
        chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/os_rx_framer.sv
module os_rx_framer
  import os_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     line_i,
  output rx_byte_t data_o,
  output logic     ok_o,
  output logic     frm_o,
  output logic     brk_o,
  output logic     glitch_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned HALF  = OSR / 2;
  localparam int unsigned IDX_W = $clog2(DATA_W);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  rx_byte_t         shift_q;
  rx_stops_t        stop_q;
  rx_stops_t        stop_full;
  logic             line_q;
  logic             fall;
  logic             at_half;
  logic             at_full;

  assign fall      = line_q && !line_i;
  assign at_half   = tick_i && (cnt_q == CNT_W'(HALF - 1));
  assign at_full   = tick_i && (cnt_q == CNT_W'(OSR - 1));
  assign stop_full = {line_i, stop_q[STOP_N-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      shift_q  <= '0;
      stop_q   <= '0;
      line_q   <= 1'b1;
      ok_o     <= 1'b0;
      frm_o    <= 1'b0;
      brk_o    <= 1'b0;
      glitch_o <= 1'b0;
    end else begin
      line_q   <= line_i;
      ok_o     <= 1'b0;
      frm_o    <= 1'b0;
      brk_o    <= 1'b0;
      glitch_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (fall) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          if (at_half) begin
            cnt_q <= '0;
            idx_q <= '0;
            if (line_i) begin
              glitch_o <= 1'b1;
              state_q  <= RX_IDLE;
            end else begin
              state_q <= RX_DATA;
            end
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_full) begin
            cnt_q   <= '0;
            shift_q <= {line_i, shift_q[DATA_W-1:1]};
            if (idx_q == IDX_W'(DATA_W - 1)) begin
              idx_q   <= '0;
              state_q <= RX_STOP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_full) begin
            cnt_q  <= '0;
            stop_q <= stop_full;
            if (idx_q == IDX_W'(STOP_N - 1)) begin
              idx_q   <= '0;
              state_q <= RX_IDLE;
              if (stops_good(stop_full)) begin
                ok_o <= 1'b1;
              end else if (frame_is_break(shift_q, stop_full)) begin
                brk_o <= 1'b1;
              end else begin
                frm_o <= 1'b1;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign data_o = shift_q;
endmodule

// File: rtl/os_rx_fifo.sv
module os_rx_fifo
  import os_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_req_i,
  input  rx_byte_t wr_data_i,
  input  logic     rd_req_i,
  output rx_byte_t rd_data_o,
  output logic     empty_o,
  output logic     full_o,
  output logic     push_o,
  output logic     pop_o,
  output logic     drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_byte_t        mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q;
  logic [AW-1:0]   rd_ptr_q;
  logic [CW-1:0]   count_q;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign pop_o   = rd_req_i && !empty_o;
  assign push_o  = wr_req_i && (!full_o || pop_o);
  assign drop_o  = wr_req_i && !push_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_o) begin
        wr_ptr_q <= ptr_next(wr_ptr_q);
      end
      if (pop_o) begin
        rd_ptr_q <= ptr_next(rd_ptr_q);
      end
      if (push_o && !pop_o) begin
        count_q <= count_q + 1'b1;
      end else if (pop_o && !push_o) begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_o) begin
      mem_q[wr_ptr_q] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/os_rx_status.sv
module os_rx_status
  import os_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
    end else begin
      stat_o <= (stat_o & ~{STAT_W{clr_i}}) | set_i;
    end
  end
endmodule

// File: rtl/os_serial_rx.sv
module os_serial_rx
  import os_rx_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o
);
  logic        line_s;
  rx_byte_t    frame_data;
  logic        frame_ok;
  logic        frame_frm;
  logic        frame_brk;
  logic        glitch_evt;
  logic        push_evt;
  logic        pop_evt;
  logic        drop_evt;
  logic        fifo_full;
  logic        fifo_empty;
  logic [STAT_W-1:0] stat_set;

  os_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  os_rx_framer #(.OSR(OSR)) framer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .line_i  (line_s),
    .data_o  (frame_data),
    .ok_o    (frame_ok),
    .frm_o   (frame_frm),
    .brk_o   (frame_brk),
    .glitch_o(glitch_evt)
  );

  os_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (frame_ok),
    .wr_data_i(frame_data),
    .rd_req_i (rd_en_i),
    .rd_data_o(rd_data_o),
    .empty_o  (fifo_empty),
    .full_o   (fifo_full),
    .push_o   (push_evt),
    .pop_o    (pop_evt),
    .drop_o   (drop_evt)
  );

  always_comb begin
    stat_set           = '0;
    stat_set[STAT_OVR] = drop_evt;
    stat_set[STAT_FRM] = frame_frm;
    stat_set[STAT_BRK] = frame_brk;
  end

  os_rx_status status_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (stat_set),
    .clr_i (stat_rd_i),
    .stat_o(stat_o)
  );

  assign rd_valid_o = !fifo_empty;
endmodule

// File: rtl/os_serial_rx_chk.sv
module os_serial_rx_chk
  import os_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              rd_en_i,
  input logic              stat_rd_i,
  input logic              rd_valid_o,
  input logic [STAT_W-1:0] stat_o,
  input logic              frame_ok,
  input logic              frame_frm,
  input logic              frame_brk,
  input logic              glitch_evt,
  input logic              push_evt,
  input logic              pop_evt,
  input logic              drop_evt,
  input logic              fifo_full
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_ok, frame_frm, frame_brk, glitch_evt})); // R6

  AST_END_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok || frame_frm || frame_brk) |-> $past(tick_i)); // R3

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full && !pop_evt) |-> !push_evt); // R4

  AST_VALID_FALLS_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_valid_o) |-> $past(rd_en_i)); // R4

  AST_OVERRUN_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_evt |=> stat_o[STAT_OVR]); // R5

  AST_FRAMING_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_frm |=> stat_o[STAT_FRM]); // R6

  AST_BREAK_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_brk |=> stat_o[STAT_BRK]); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o))); // R8
endmodule

bind os_serial_rx os_serial_rx_chk chk_i (.*);

// File: tb/os_serial_rx_tb_top.sv
`timescale 1ns/1ps
module os_serial_rx_tb_top;
  localparam int BIT_CLKS = 64;   // 16 enables x 4 clocks
  localparam int FRAME_ITERS = 11 * BIT_CLKS + 2 * BIT_CLKS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b1;
  logic       rd_en = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [2:0] stat;
  logic [1:0] tph = 2'd0;
  logic       tick;

  int checks = 0;
  int fails = 0;
  int rise_at = -1;
  int meas_n = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) tph <= tph + 2'd1;
  assign tick = (tph == 2'd3);

  os_serial_rx dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .line_i    (line),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .rd_valid_o(rd_valid),
    .stat_rd_i (stat_rd),
    .stat_o    (stat)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // mode: 0 none, 1 status-read pulse, 2 queue-read pulse, at iteration pulse_at-1
  task automatic send_frame(input logic [7:0] d, input logic [1:0] stops,
                            input int mode, input int pulse_at);
    logic [10:0] bits;
    bits = {stops[1], stops[0], d, 1'b0};
    rise_at = -1;
    @(negedge clk);
    while (tph != 2'd0) @(negedge clk);
    for (int k = 0; k < FRAME_ITERS; k++) begin
      if (k > 0) @(negedge clk);
      if (rise_at < 0 && (stat[1] || rd_valid)) rise_at = k;
      line = (k < 11 * BIT_CLKS) ? bits[k / BIT_CLKS] : 1'b1;
      if (mode == 1) stat_rd = (k == pulse_at - 1);
      if (mode == 2) rd_en   = (k == pulse_at - 1);
    end
    stat_rd = 1'b0;
    rd_en = 1'b0;
    line = 1'b1;
    @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {31'd0, rd_valid}, 32'd1);
    chk(req, {24'd0, rd_data}, {24'd0, exp});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, rd_valid}, 32'd0);
    chk("R1 status after reset", {29'd0, stat}, 32'd0);
  endtask

  task automatic t_idle_glitch();
    repeat (400) @(negedge clk);
    chk("R2 idle high line", {31'd0, rd_valid}, 32'd0);
    while (tph != 2'd0) @(negedge clk);
    line = 1'b0;
    repeat (16) @(negedge clk);
    line = 1'b1;
    repeat (13 * BIT_CLKS) @(negedge clk);
    chk("R2 glitch no byte", {31'd0, rd_valid}, 32'd0);
    chk("R2 glitch no status", {29'd0, stat}, 32'd0);
  endtask

  task automatic t_single();
    send_frame(8'hA5, 2'b11, 0, 0);
    chk("R3 status clean", {29'd0, stat}, 32'd0);
    pop_chk("R3 byte A5", 8'hA5);
    send_frame(8'h01, 2'b11, 0, 0);
    pop_chk("R3 lsb-first 01", 8'h01);
    send_frame(8'h80, 2'b11, 0, 0);
    pop_chk("R3 lsb-first 80", 8'h80);
    @(negedge clk);
    chk("R4 empty after pops", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_fifo_order();
    send_frame(8'h11, 2'b11, 0, 0);
    send_frame(8'h22, 2'b11, 0, 0);
    send_frame(8'h33, 2'b11, 0, 0);
    send_frame(8'h44, 2'b11, 0, 0);
    chk("R4 four held no overrun", {29'd0, stat}, 32'd0);
    pop_chk("R4 order 1", 8'h11);
    pop_chk("R4 order 2", 8'h22);
    pop_chk("R4 order 3", 8'h33);
    pop_chk("R4 order 4", 8'h44);
    @(negedge clk);
    chk("R4 drained", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_overrun();
    send_frame(8'hC1, 2'b11, 0, 0);
    send_frame(8'hC2, 2'b11, 0, 0);
    send_frame(8'hC3, 2'b11, 0, 0);
    send_frame(8'hC4, 2'b11, 0, 0);
    send_frame(8'hC5, 2'b11, 0, 0);
    chk("R5 overrun bit0", {29'd0, stat}, 32'd1);
    pop_chk("R5 kept 1", 8'hC1);
    pop_chk("R5 kept 2", 8'hC2);
    pop_chk("R5 kept 3", 8'hC3);
    pop_chk("R5 kept 4", 8'hC4);
    @(negedge clk);
    chk("R5 fifth lost", {31'd0, rd_valid}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R8 sticky without read", {29'd0, stat}, 32'd1);
    clear_status();
    chk("R8 cleared by read", {29'd0, stat}, 32'd0);
  endtask

  task automatic t_framing();
    send_frame(8'h5A, 2'b01, 0, 0);   // first stop high, second low
    chk("R6 second stop low", {29'd0, stat}, 32'd2);
    chk("R6 byte discarded", {31'd0, rd_valid}, 32'd0);
    clear_status();
    send_frame(8'h5A, 2'b10, 0, 0);   // first stop low
    chk("R6 first stop low", {29'd0, stat}, 32'd2);
    clear_status();
    send_frame(8'h00, 2'b01, 0, 0);   // zero data but a high stop: not a break
    chk("R6 zero data not break", {29'd0, stat}, 32'd2);
    clear_status();
  endtask

  task automatic t_break();
    send_frame(8'h00, 2'b00, 0, 0);
    chk("R7 break bit only", {29'd0, stat}, 32'd4);
    chk("R7 no byte", {31'd0, rd_valid}, 32'd0);
    clear_status();
    send_frame(8'h3C, 2'b11, 0, 0);
    pop_chk("R7 recovers after break", 8'h3C);
  endtask

  task automatic t_races();
    send_frame(8'h5A, 2'b01, 0, 0);
    meas_n = rise_at;
    chk("R6 end visible in frame", {31'd0, (meas_n > 0)}, 32'd1);
    clear_status();
    send_frame(8'hD1, 2'b11, 0, 0);
    send_frame(8'hD2, 2'b11, 0, 0);
    send_frame(8'hD3, 2'b11, 0, 0);
    send_frame(8'hD4, 2'b11, 0, 0);
    send_frame(8'hD5, 2'b11, 0, 0);
    chk("R5 overrun before race", {29'd0, stat}, 32'd1);
    send_frame(8'h5A, 2'b01, 1, meas_n);
    chk("R8 set wins over clear", {29'd0, stat}, 32'd2);
    clear_status();
    send_frame(8'h66, 2'b11, 2, meas_n);
    chk("R9 no overrun on pop+push", {29'd0, stat}, 32'd0);
    pop_chk("R9 order 1", 8'hD2);
    pop_chk("R9 order 2", 8'hD3);
    pop_chk("R9 order 3", 8'hD4);
    pop_chk("R9 new byte kept", 8'h66);
    @(negedge clk);
    chk("R9 drained", {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_glitch();
    t_single();
    t_fifo_order();
    t_overrun();
    t_framing();
    t_break();
    t_races();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule